// File: doc/BRIEF.md
# Text-Mode Character Pixel Generator

This block is one stage of a raster video pipeline. It receives the pixel clock, a per-pixel clock enable, separate horizontal and vertical display-enable strobes and the two sync signals from an upstream timing generator. It keeps its own pixel column and line coordinates, which restart at every active window. It turns each coordinate pair into a character cell. A tile map of character codes is read for that cell. The code and the line within the glyph then address a font memory that holds one byte per glyph line. One bit of that byte chooses between a foreground and a background colour.

Both lookups are synchronous single-cycle memories, so the sync and enable signals are carried through a delay line of the same length. The colour, syncs and enables therefore leave the block on the same pixel. Outside the joint horizontal and vertical window the colour is forced to black, and a combined data-enable is produced for digital display transmitters. The tile map is a power of two wider than the visible text, so cells beyond the right edge can hold data prepared ahead of time.

Top module: `txt_char_gen`

## Requirements
- R1: The column coordinate is cleared on every enabled pixel where `hde_in` is low, and on every enabled pixel where `hde_in` is high it goes up by one from the value the current pixel used. The first active pixel of a line therefore has column 0.
- R2: The line coordinate is cleared on every enabled pixel where `vde_in` is low. While `vde_in` is high it goes up by one on the single enabled pixel where `hde_in` is low and the previous enabled sample of `hde_in` was high.
- R3: On clock edges with `pix_en` low, no coordinate, pipeline stage or output changes, whatever values the other inputs carry.
- R4: The tile map address is {tile_row, tile_col}, with tile_col in the low `MAP_COL_BITS` bits. tile_col is the column coordinate shifted right by 3+`DOT_SCALE` and truncated to `MAP_COL_BITS` bits, so the map wraps horizontally. tile_row is formed the same way from the line coordinate with `MAP_ROW_BITS` bits.
- R5: The font address is {code[7:0], glyph_row[2:0]}, where glyph_row is bits `DOT_SCALE`+2 down to `DOT_SCALE` of the line coordinate. The dot column is taken from the same bits of the column coordinate. With `DOT_SCALE`=1 each font dot covers 2 pixels by 2 lines.
- R6: Font bit 7 is the leftmost dot of a glyph line. A set bit gives `FG_RGB` and a clear bit gives `BG_RGB`. Both are packed as {red, green, blue}, each `RGB_W` bits wide.
- R7: `hs_out`, `vs_out`, `hde_out` and `vde_out` equal `hs_in`, `vs_in`, `hde_in` and `vde_in` as they were sampled three enabled pixels earlier. The colour on the same cycle belongs to that same input pixel.
- R8: `de_out` is high exactly when the delayed horizontal and vertical enables are both high. While it is low, `red`, `grn` and `blu` are all zero.
- R9: While `rst` is high, all outputs are zero after the next clock edge, and the coordinates and the delay line restart from zero.
- R10: The test contents are computed as follows. The tile map entry at address a holds (13·a + 5) mod 256. The font byte at address a holds (a >> 3) XOR ((37·a) mod 256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Pixel clock enable; state advances only when high |
| hde_in | input | 1 | Horizontal display enable from the timing generator |
| vde_in | input | 1 | Vertical display enable from the timing generator |
| hs_in | input | 1 | Horizontal sync from the timing generator |
| vs_in | input | 1 | Vertical sync from the timing generator |
| hs_out | output | 1 | Horizontal sync, latency matched |
| vs_out | output | 1 | Vertical sync, latency matched |
| hde_out | output | 1 | Horizontal display enable, latency matched |
| vde_out | output | 1 | Vertical display enable, latency matched |
| de_out | output | 1 | Combined data enable for digital transmitters |
| red | output | RGB_W | Red pixel component |
| grn | output | RGB_W | Green pixel component |
| blu | output | RGB_W | Blue pixel component |

## Verification
The bench builds the block with a 16-column by 4-row tile map, 2-bit colour channels and doubled dots. It drives a 288-pixel by 80-line active window. That window spans 18 cell columns and 5 cell rows, so both horizontal and vertical map wrap-around appear in a single frame, and every glyph line and every dot position of many codes is shown. The background colour is set non-zero, so a muted pixel can be told apart from a background pixel. Moving the active window inside the raster checks that the coordinates follow the enables and not the raster position.

// File: rtl/txt_char_gen_pkg.sv
package txt_char_gen_pkg;

  localparam int GLYPH_LOG2 = 3;

  // cell index: drop the in-glyph bits and the dot-doubling bits
  function automatic int unsigned cell_index(input int unsigned coord, input int unsigned scale);
    return coord >> (GLYPH_LOG2 + scale);
  endfunction

  // index of the dot (or glyph line) inside an 8x8 glyph
  function automatic int unsigned dot_index(input int unsigned coord, input int unsigned scale);
    return (coord >> scale) & 32'd7;
  endfunction

  // leftmost dot is bit 7
  function automatic logic pick_dot(input logic [7:0] glyph_bits, input logic [2:0] dot_col);
    return glyph_bits[3'd7 - dot_col];
  endfunction

  function automatic logic [7:0] map_seed(input int unsigned a);
    return 8'((a * 32'd13 + 32'd5) & 32'hFF);
  endfunction

  function automatic logic [7:0] font_seed(input int unsigned a);
    return 8'(((a >> 3) ^ (a * 32'd37)) & 32'hFF);
  endfunction

endpackage

// File: rtl/txt_raster_count.sv
module txt_raster_count #(
  parameter int X_W = 10,
  parameter int Y_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pix_en,
  input  logic           hde_in,
  input  logic           vde_in,
  output logic [X_W-1:0] col,
  output logic [Y_W-1:0] row,
  output logic           line_end
);

  logic hde_prev;

  // falling edge of the horizontal enable, in enabled-pixel time
  assign line_end = !hde_in && hde_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      col      <= '0;
      row      <= '0;
      hde_prev <= 1'b0;
    end else if (pix_en) begin
      hde_prev <= hde_in;
      col      <= hde_in ? col + 1'b1 : '0;
      if (!vde_in)       row <= '0;
      else if (line_end) row <= row + 1'b1;
    end
  end

endmodule

// File: rtl/txt_sync_mem.sv
module txt_sync_mem
  import txt_char_gen_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DW      = 8,
  parameter int CONTENT = 0   // 0: tile map pattern, 1: font pattern
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  generate
    if (CONTENT == 0) begin : g_map_fill
      initial for (int i = 0; i < DEPTH; i++) mem[i] = DW'(map_seed(i));
    end else begin : g_font_fill
      initial for (int i = 0; i < DEPTH; i++) mem[i] = DW'(font_seed(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end

endmodule

// File: rtl/txt_delay_pipe.sv
module txt_delay_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/txt_char_gen.sv
module txt_char_gen
  import txt_char_gen_pkg::*;
#(
  parameter int RGB_W        = 2,
  parameter int X_W          = 10,
  parameter int Y_W          = 10,
  parameter int MAP_COL_BITS = 7,
  parameter int MAP_ROW_BITS = 5,
  parameter int DOT_SCALE    = 1,
  parameter logic [3*RGB_W-1:0] FG_RGB = '1,
  parameter logic [3*RGB_W-1:0] BG_RGB = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_en,
  input  logic             hde_in,
  input  logic             vde_in,
  input  logic             hs_in,
  input  logic             vs_in,
  output logic             hs_out,
  output logic             vs_out,
  output logic             hde_out,
  output logic             vde_out,
  output logic             de_out,
  output logic [RGB_W-1:0] red,
  output logic [RGB_W-1:0] grn,
  output logic [RGB_W-1:0] blu
);

  localparam int CODE_W  = 8;
  localparam int MAP_AW  = MAP_COL_BITS + MAP_ROW_BITS;
  localparam int FONT_AW = CODE_W + GLYPH_LOG2;
  localparam int PIX_W   = 3 * RGB_W;
  localparam int TAG_W   = GLYPH_LOG2 + 4;   // dot column + four timing bits

  // stage 0: coordinates of the pixel on the inputs
  logic [X_W-1:0] col_q;
  logic [Y_W-1:0] row_q;
  logic           line_end;

  txt_raster_count #(.X_W(X_W), .Y_W(Y_W)) u_count (
    .clk(clk), .rst(rst), .pix_en(pix_en),
    .hde_in(hde_in), .vde_in(vde_in),
    .col(col_q), .row(row_q), .line_end(line_end)
  );

  logic [MAP_COL_BITS-1:0] tile_col;
  logic [MAP_ROW_BITS-1:0] tile_row;
  logic [GLYPH_LOG2-1:0]   glyph_row, dot_col;
  logic [MAP_AW-1:0]       map_addr;

  assign tile_col  = MAP_COL_BITS'(cell_index(32'(col_q), DOT_SCALE));
  assign tile_row  = MAP_ROW_BITS'(cell_index(32'(row_q), DOT_SCALE));
  assign glyph_row = GLYPH_LOG2'(dot_index(32'(row_q), DOT_SCALE));
  assign dot_col   = GLYPH_LOG2'(dot_index(32'(col_q), DOT_SCALE));
  assign map_addr  = {tile_row, tile_col};

  // stage 1: character code
  logic [CODE_W-1:0] code;

  txt_sync_mem #(.AW(MAP_AW), .DW(CODE_W), .CONTENT(0)) u_tile_map (
    .clk(clk), .rd_en(pix_en), .addr(map_addr), .q(code)
  );

  logic [GLYPH_LOG2-1:0] glyph_row_s1;

  txt_delay_pipe #(.W(GLYPH_LOG2), .DEPTH(1)) u_row_pipe (
    .clk(clk), .rst(rst), .en(pix_en), .d(glyph_row), .q(glyph_row_s1)
  );

  // stage 2: glyph line bits
  logic [7:0] glyph_bits;

  txt_sync_mem #(.AW(FONT_AW), .DW(8), .CONTENT(1)) u_font (
    .clk(clk), .rd_en(pix_en), .addr({code, glyph_row_s1}), .q(glyph_bits)
  );

  logic [TAG_W-1:0] tag_s2;

  txt_delay_pipe #(.W(TAG_W), .DEPTH(2)) u_tag_pipe (
    .clk(clk), .rst(rst), .en(pix_en),
    .d({dot_col, hs_in, vs_in, hde_in, vde_in}), .q(tag_s2)
  );

  logic [GLYPH_LOG2-1:0] dot_col_s2;
  logic hs_s2, vs_s2, hde_s2, vde_s2, live_s2;
  logic [PIX_W-1:0] colour_s2;

  assign {dot_col_s2, hs_s2, vs_s2, hde_s2, vde_s2} = tag_s2;
  assign live_s2   = hde_s2 && vde_s2;
  assign colour_s2 = pick_dot(glyph_bits, dot_col_s2) ? FG_RGB : BG_RGB;

  // stage 3: registered outputs, muted outside the window
  always_ff @(posedge clk) begin
    if (rst) begin
      {hs_out, vs_out, hde_out, vde_out, de_out} <= '0;
      {red, grn, blu} <= '0;
    end else if (pix_en) begin
      {hs_out, vs_out, hde_out, vde_out} <= {hs_s2, vs_s2, hde_s2, vde_s2};
      de_out          <= live_s2;
      {red, grn, blu} <= live_s2 ? colour_s2 : '0;
    end
  end

endmodule

// File: rtl/txt_char_gen_chk.sv
module txt_char_gen_chk #(
  parameter int X_W   = 10,
  parameter int Y_W   = 10,
  parameter int PIX_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             pix_en,
  input logic             hde_in,
  input logic             vde_in,
  input logic [X_W-1:0]   col,
  input logic [Y_W-1:0]   row,
  input logic             line_end,
  input logic             hs_out,
  input logic             vs_out,
  input logic             hde_out,
  input logic             vde_out,
  input logic             de_out,
  input logic [PIX_W-1:0] rgb
);

  logic [X_W-1:0] col_nxt;
  logic [Y_W-1:0] row_nxt;
  assign col_nxt = col + 1'b1;
  assign row_nxt = row + 1'b1;

  AST_COL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pix_en && !hde_in |=> col == '0);                                   // R1
  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    pix_en && hde_in |=> col == $past(col_nxt));                        // R1
  AST_ROW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    pix_en && !vde_in |=> row == '0);                                   // R2
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
    pix_en && vde_in && line_end |=> row == $past(row_nxt));            // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> $stable(col) && $stable(row) && $stable(rgb) && $stable(de_out)
      && $stable(hs_out) && $stable(vs_out));                           // R3
  AST_DE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    de_out |-> hde_out && vde_out);                                     // R8
  AST_MUTE_BLACK: assert property (@(posedge clk) disable iff (rst)
    !de_out |-> rgb == '0);                                             // R8

endmodule

bind txt_char_gen txt_char_gen_chk #(.X_W(X_W), .Y_W(Y_W), .PIX_W(3*RGB_W)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .hde_in(hde_in), .vde_in(vde_in),
  .col(col_q), .row(row_q), .line_end(line_end),
  .hs_out(hs_out), .vs_out(vs_out), .hde_out(hde_out), .vde_out(vde_out),
  .de_out(de_out), .rgb({red, grn, blu})
);

// File: tb/txt_char_gen_test.sv
`timescale 1ns/1ps
module txt_char_gen_test;

  localparam int RGB_W = 2, X_W = 10, Y_W = 10, MCB = 4, MRB = 2, SCL = 1;
  localparam logic [5:0] FG = 6'b11_10_01;
  localparam logic [5:0] BG = 6'b00_01_10;
  localparam int HA = 288, HT = 300, VA = 80, VT = 84;

  logic clk = 1'b0, rst = 1'b1, pix_en = 1'b0;
  logic hde_in = 1'b0, vde_in = 1'b0, hs_in = 1'b0, vs_in = 1'b0;
  logic hs_out, vs_out, hde_out, vde_out, de_out;
  logic [RGB_W-1:0] red, grn, blu;

  always #2.5 clk = ~clk;

  txt_char_gen #(
    .RGB_W(RGB_W), .X_W(X_W), .Y_W(Y_W), .MAP_COL_BITS(MCB), .MAP_ROW_BITS(MRB),
    .DOT_SCALE(SCL), .FG_RGB(FG), .BG_RGB(BG)
  ) uut (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hde_in(hde_in), .vde_in(vde_in),
    .hs_in(hs_in), .vs_in(vs_in), .hs_out(hs_out), .vs_out(vs_out),
    .hde_out(hde_out), .vde_out(vde_out), .de_out(de_out),
    .red(red), .grn(grn), .blu(blu)
  );

  typedef struct packed {
    logic hs, vs, hde, vde, de;
    logic [5:0] rgb;
  } exp_t;

  exp_t h0 = '0, h1 = '0, h2 = '0;
  int hoff = 0, voff = 0;
  int vectors = 0, fails = 0;
  string tag = "";
  bit done = 1'b0;

  // R4 R5 R6 R10: colour of text coordinate (x, y)
  function automatic logic [5:0] dot_color(int x, int y);
    int tc, tr, a, code, fa, gbyte, dot;
    tc    = (x / (8 << SCL)) % (1 << MCB);
    tr    = (y / (8 << SCL)) % (1 << MRB);
    a     = tr * (1 << MCB) + tc;
    code  = (13 * a + 5) % 256;
    fa    = code * 8 + (y / (1 << SCL)) % 8;
    gbyte = code ^ ((37 * fa) % 256);
    dot   = (gbyte >> (7 - (x / (1 << SCL)) % 8)) & 1;
    return (dot != 0) ? FG : BG;
  endfunction

  function automatic exp_t exp_of(int px, int ln);
    exp_t e;
    e.hde = (px >= hoff) && (px < hoff + HA);
    e.vde = (ln >= voff) && (ln < voff + VA);
    e.hs  = (px >= HT - 6) && (px < HT - 1);
    e.vs  = (ln >= VT - 3) && (ln < VT - 1);
    e.de  = e.hde && e.vde;
    e.rgb = e.de ? dot_color(px - hoff, ln - voff) : 6'b0;
    return e;
  endfunction

  task automatic check();
    exp_t a;
    string t;
    bit bad;
    a = '{hs: hs_out, vs: vs_out, hde: hde_out, vde: vde_out, de: de_out, rgb: {red, grn, blu}};
    bad = 1'b0;
    vectors++;
    if ({a.hs, a.vs, a.hde, a.vde} != {h2.hs, h2.vs, h2.hde, h2.vde}) begin
      t = (tag != "") ? tag : "R7";
      $display("FAIL %s timing: actual=%b expected=%b", t,
               {a.hs, a.vs, a.hde, a.vde}, {h2.hs, h2.vs, h2.hde, h2.vde});
      bad = 1'b1;
    end
    if (a.de != h2.de) begin
      t = (tag != "") ? tag : "R8";
      $display("FAIL %s de_out: actual=%b expected=%b", t, a.de, h2.de);
      bad = 1'b1;
    end
    if (a.rgb != h2.rgb) begin
      t = (tag != "") ? tag : (h2.de ? "R1 R2 R4 R5 R6 R10" : "R8");
      $display("FAIL %s pixel: actual=%b expected=%b", t, a.rgb, h2.rgb);
      bad = 1'b1;
    end
    if (bad) fails++;
  endtask

  // one clock: check the state after the last edge, then drive the next edge
  task automatic step(bit en, int px, int ln);
    exp_t e;
    @(negedge clk);
    check();
    e = exp_of(px, ln);
    pix_en = en;
    {hs_in, vs_in, hde_in, vde_in} = {e.hs, e.vs, e.hde, e.vde};
    if (en) begin
      h2 = h1; h1 = h0; h0 = e;
    end
  endtask

  // R3: idle cycles with scrambled inputs
  task automatic hold(int n);
    tag = "R3";
    repeat (n) begin
      @(negedge clk);
      check();
      pix_en = 1'b0;
      {hs_in, vs_in, hde_in, vde_in} = 4'($urandom);
    end
    tag = "";
  endtask

  // R9: synchronous reset, outputs checked while it is held
  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    pix_en = 1'($urandom);
    {hs_in, vs_in, hde_in, vde_in} = 4'($urandom);
    h0 = '0; h1 = '0; h2 = '0;
    @(negedge clk);
    tag = "R9";
    repeat (n) begin
      check();
      @(negedge clk);
    end
    tag = "";
    rst = 1'b0;
    pix_en = 1'b0;
  endtask

  task automatic run_frame(int prob, int lines, int hold_at);
    int slot = 0;
    for (int ln = 0; ln < lines; ln++) begin
      for (int px = 0; px < HT; px++) begin
        bit en;
        do begin
          en = (int'($urandom % 100) < prob);
          step(en, px, ln);
        end while (!en);
        slot++;
        if (slot == hold_at) hold(40);
      end
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset(4);
    hoff = 0; voff = 0;
    run_frame(100, VT, -1);          // full rate, window at raster origin
    hoff = 3; voff = 1;
    run_frame(70, VT, 9000);         // gapped enable, shifted window, idle stretch
    hoff = 1; voff = 0;
    run_frame(80, 20, -1);           // interrupted frame
    do_reset(3);
    run_frame(75, 44, 2000);         // restart from the top after reset
    hold(5);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL R7 watchdog: actual=stalled expected=finished");
      summary();
      $finish;
    end
  end

endmodule